// File: doc/BRIEF.md
# Parallel-Port Nibble Register Access Sequencer

This engine runs on the host side of a legacy parallel port and performs one register access at a time on a drive-bridge adapter at the far end. It drives the eight data lines and the four control lines and reads the eight status lines. A caller supplies an operation code, a bank select, a three-bit register index and a write byte. The engine then plays back a fixed pattern of control-line values. Each pattern latches a bus address in the adapter and then moves one byte. Two further operations open and close a session on the port.

A read returns its byte in four-bit halves. The adapter drives each half onto the upper status lines, and the engine joins the two samples into one byte. Every control-line value is held for a programmable number of clocks so that slow adapters keep up. The hold setting is taken when a request is accepted.

Top module: `pp_nibble_seq`

## Requirements
- R1: After reset, pp_ctrl is 0x4, pp_data is 0x00, busy is 0, done is 0 and rdata is 0x00.
- R2: For read and write, the bus address on pp_data is req_index + 0x08 when req_cmdset is 0 (register bank) and req_index + 0x10 when req_cmdset is 1 (command bank). req_op encodings: 0 read, 1 write, 2 open, 3 close.
- R3: Every read, write and close starts with an address latch. In the first step pp_ctrl is 0x4 and the address is on pp_data. The next seven steps drive pp_ctrl to 0xC, 0xE, 0xE, 0xC, 0x4, 0x4, 0x4, and pp_data holds the address throughout.
- R4: After the latch, a read drives pp_ctrl to 0x6 for one step and then 0x4 for two steps. pp_status is sampled in the last clock of the 0x6 step (low sample) and in the last clock of the first 0x4 step (high sample).
- R5: A read's rdata is {high sample[7:4], low sample[7:4]}, so status bits 3:0 are ignored. rdata changes only when a read completes.
- R6: After the latch, a write puts req_wdata on pp_data with pp_ctrl 0x4 for one step. It then steps pp_ctrl through 0x5, 0x7, 0x5, 0x4, with the write byte held on pp_data.
- R7: An open saves the current pp_data and pp_ctrl and drives pp_ctrl to 0x4 in its single step. pp_data is left unchanged.
- R8: A close latches address 0x20 with the R3 pattern. A final step then restores the pp_data and pp_ctrl values saved by the last open (0x00 and 0x4 if no open has occurred).
- R9: Each step holds its outputs for cfg_hold+1 clocks. cfg_hold is captured at acceptance, and later changes do not affect the running operation.
- R10: busy rises in the clock after acceptance and stays high for steps×(cfg_hold+1) clocks. done pulses for exactly one clock as busy falls, and done and busy are never high together.
- R11: A request presented while busy is high is dropped. It neither alters the running pattern nor starts a later operation.
- R12: While idle with no request, pp_ctrl and pp_data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold | input | HOLD_W | Extra hold clocks per step |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 read, 1 write, 2 open, 3 close |
| req_cmdset | input | 1 | Bank select: 0 register bank, 1 command bank |
| req_index | input | 3 | Register index |
| req_wdata | input | 8 | Byte to write |
| pp_status | input | 8 | Port status lines |
| pp_data | output | 8 | Port data lines |
| pp_ctrl | output | 4 | Port control lines |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last byte read |

## Verification
The bench models the adapter as status lines that follow pp_ctrl. The value changes when the control lines read 0x6, and the lower status nibbles carry junk. A sequencer that samples one clock late captures the wrong half, and one that uses the lower nibbles returns a corrupted byte. Every operation is traced clock by clock with hold values of 0 to 3 and compared against the step pattern. An off-by-one in the hold counter therefore shows up as a shifted or missing step, and so does a skipped 0xE repeat in the latch pattern. Further scenarios change cfg_hold during an operation, issue a request while busy, and run a read between an open and a close. These expose a hold value taken live rather than at acceptance, a request that is queued instead of dropped, and a close that restores the current data instead of the value saved by the open.

// File: rtl/pp_seq_pkg.sv
`timescale 1ns/1ps
package pp_seq_pkg;

    localparam int STEP_W = 4;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_OPEN  = 2'd2,
        OP_CLOSE = 2'd3
    } pp_op_e;

    typedef enum logic [1:0] {
        DS_KEEP  = 2'd0,
        DS_ADDR  = 2'd1,
        DS_WDATA = 2'd2,
        DS_SAVED = 2'd3
    } dsel_e;

    typedef enum logic [1:0] {
        SM_NONE = 2'd0,
        SM_LO   = 2'd1,
        SM_HI   = 2'd2
    } smp_e;

    typedef struct packed {
        logic [3:0] ctrl;
        logic       ctrl_saved;
        dsel_e      dsel;
        smp_e       smp;
        logic       last;
    } step_t;

    localparam logic [3:0] CTRL_IDLE  = 4'h4;
    localparam logic [3:0] CTRL_SEL   = 4'hC;
    localparam logic [3:0] CTRL_SELCK = 4'hE;
    localparam logic [3:0] CTRL_RDSTB = 4'h6;
    localparam logic [3:0] CTRL_WRARM = 4'h5;
    localparam logic [3:0] CTRL_WRSTB = 4'h7;

    localparam logic [7:0] BASE_REGS  = 8'h08;
    localparam logic [7:0] BASE_CMDS  = 8'h10;
    localparam logic [7:0] CLOSE_ADDR = 8'h20;
    localparam logic [7:0] DATA_RESET = 8'h00;

    function automatic logic [3:0] latch_ctrl(input logic [2:0] idx);
        case (idx)
            3'd1:    return CTRL_SEL;
            3'd2:    return CTRL_SELCK;
            3'd3:    return CTRL_SELCK;
            3'd4:    return CTRL_SEL;
            default: return CTRL_IDLE;
        endcase
    endfunction

    function automatic logic [7:0] bus_addr(input logic cmdset, input logic [2:0] index);
        return (cmdset ? BASE_CMDS : BASE_REGS) + {5'd0, index};
    endfunction

    function automatic step_t step_of(input pp_op_e op, input logic [STEP_W-1:0] idx);
        step_t s;
        s.ctrl       = CTRL_IDLE;
        s.ctrl_saved = 1'b0;
        s.dsel       = DS_KEEP;
        s.smp        = SM_NONE;
        s.last       = 1'b1;
        if (op != OP_OPEN && idx < STEP_W'(8)) begin
            s.ctrl = latch_ctrl(idx[2:0]);
            s.dsel = (idx == '0) ? DS_ADDR : DS_KEEP;
            s.last = 1'b0;
        end else begin
            case (op)
                OP_READ: begin
                    if (idx == STEP_W'(8)) begin
                        s.ctrl = CTRL_RDSTB;
                        s.smp  = SM_LO;
                        s.last = 1'b0;
                    end else if (idx == STEP_W'(9)) begin
                        s.smp  = SM_HI;
                        s.last = 1'b0;
                    end
                end
                OP_WRITE: begin
                    case (idx)
                        STEP_W'(8):  begin s.dsel = DS_WDATA; s.last = 1'b0; end
                        STEP_W'(9):  begin s.ctrl = CTRL_WRARM; s.last = 1'b0; end
                        STEP_W'(10): begin s.ctrl = CTRL_WRSTB; s.last = 1'b0; end
                        STEP_W'(11): begin s.ctrl = CTRL_WRARM; s.last = 1'b0; end
                        default:     ;
                    endcase
                end
                OP_CLOSE: begin
                    s.ctrl_saved = 1'b1;
                    s.dsel       = DS_SAVED;
                end
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pp_step_rom.sv
`timescale 1ns/1ps
module pp_step_rom
    import pp_seq_pkg::*;
(
    input  pp_op_e              op,
    input  logic [STEP_W-1:0]   idx,
    output step_t               step
);
    assign step = step_of(op, idx);
endmodule

// File: rtl/pp_hold_timer.sv
`timescale 1ns/1ps
module pp_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HOLD_W-1:0] limit,
    output logic              expire
);
    logic [HOLD_W-1:0] cnt_q;

    assign expire = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pp_nibble_join.sv
`timescale 1ns/1ps
module pp_nibble_join (
    input  logic       clk,
    input  logic       rst,
    input  logic       take_lo,
    input  logic       take_hi,
    input  logic [7:0] status,
    output logic [7:0] joined
);
    logic [3:0] lo_q;
    logic [3:0] hi_q;
    logic       unused_status_low;

    assign unused_status_low = ^status[3:0];
    assign joined = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (take_lo) lo_q <= status[7:4];
            if (take_hi) hi_q <= status[7:4];
        end
    end
endmodule

// File: rtl/pp_nibble_seq.sv
`timescale 1ns/1ps
module pp_nibble_seq
    import pp_seq_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_cmdset,
    input  logic [2:0]        req_index,
    input  logic [7:0]        req_wdata,
    input  logic [7:0]        pp_status,
    output logic [7:0]        pp_data,
    output logic [3:0]        pp_ctrl,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rdata
);
    pp_op_e            op_q;
    logic [STEP_W-1:0] step_q;
    logic [7:0]        addr_q;
    logic [7:0]        wdata_q;
    logic [HOLD_W-1:0] hold_q;
    logic [7:0]        saved_data_q;
    logic [3:0]        saved_ctrl_q;
    logic [7:0]        data_q;
    logic [3:0]        ctrl_q;
    logic              busy_q;
    logic              done_q;
    logic [7:0]        rdata_q;

    pp_op_e            req_op_e;
    logic [7:0]        req_addr;
    step_t             st_cur;
    step_t             st_nxt;
    step_t             st_first;
    logic              expire;
    logic [7:0]        joined;
    logic              take_lo;
    logic              take_hi;
    logic              unused_step_bits;

    assign req_op_e = pp_op_e'(req_op);
    assign req_addr = (req_op_e == OP_CLOSE) ? CLOSE_ADDR : bus_addr(req_cmdset, req_index);

    pp_step_rom u_rom_cur   (.op(op_q),     .idx(step_q),          .step(st_cur));
    pp_step_rom u_rom_nxt   (.op(op_q),     .idx(step_q + 1'b1),   .step(st_nxt));
    pp_step_rom u_rom_first (.op(req_op_e), .idx('0),              .step(st_first));

    assign unused_step_bits = ^{st_first.smp, st_first.last, st_nxt.smp, st_nxt.last,
                                st_cur.ctrl, st_cur.ctrl_saved, st_cur.dsel};

    pp_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (busy_q),
        .limit  (hold_q),
        .expire (expire)
    );

    assign take_lo = expire && (st_cur.smp == SM_LO);
    assign take_hi = expire && (st_cur.smp == SM_HI);

    pp_nibble_join u_join (
        .clk     (clk),
        .rst     (rst),
        .take_lo (take_lo),
        .take_hi (take_hi),
        .status  (pp_status),
        .joined  (joined)
    );

    function automatic logic [7:0] pick_data(input dsel_e sel, input logic [7:0] keep,
                                             input logic [7:0] addr, input logic [7:0] wd,
                                             input logic [7:0] saved);
        case (sel)
            DS_ADDR:  return addr;
            DS_WDATA: return wd;
            DS_SAVED: return saved;
            default:  return keep;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q         <= OP_READ;
            step_q       <= '0;
            addr_q       <= '0;
            wdata_q      <= '0;
            hold_q       <= '0;
            saved_data_q <= DATA_RESET;
            saved_ctrl_q <= CTRL_IDLE;
            data_q       <= DATA_RESET;
            ctrl_q       <= CTRL_IDLE;
            busy_q       <= 1'b0;
            done_q       <= 1'b0;
            rdata_q      <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (req_valid) begin
                    op_q    <= req_op_e;
                    step_q  <= '0;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    hold_q  <= cfg_hold;
                    busy_q  <= 1'b1;
                    if (req_op_e == OP_OPEN) begin
                        saved_data_q <= data_q;
                        saved_ctrl_q <= ctrl_q;
                    end
                    ctrl_q <= st_first.ctrl_saved ? saved_ctrl_q : st_first.ctrl;
                    data_q <= pick_data(st_first.dsel, data_q, req_addr, req_wdata, saved_data_q);
                end
            end else if (expire) begin
                if (st_cur.last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (op_q == OP_READ) rdata_q <= joined;
                end else begin
                    step_q <= step_q + 1'b1;
                    ctrl_q <= st_nxt.ctrl_saved ? saved_ctrl_q : st_nxt.ctrl;
                    data_q <= pick_data(st_nxt.dsel, data_q, addr_q, wdata_q, saved_data_q);
                end
            end
        end
    end

    assign pp_data = data_q;
    assign pp_ctrl = ctrl_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign rdata   = rdata_q;
endmodule

// File: rtl/pp_nibble_seq_chk.sv
`timescale 1ns/1ps
module pp_nibble_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic [3:0] pp_ctrl,
    input logic [7:0] pp_data
);
    // R10: completion pulse only while idle
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R10: completion pulse lasts one clock
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R3: control lines only take values from the step patterns
    p_ctrl_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (pp_ctrl == 4'h4 || pp_ctrl == 4'h5 || pp_ctrl == 4'h6 ||
         pp_ctrl == 4'h7 || pp_ctrl == 4'hC || pp_ctrl == 4'hE));

    // R3: every operation begins with control at 0x4
    p_first_step_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (pp_ctrl == 4'h4));

    // R12: idle outputs hold when no request is presented
    p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> ($stable(pp_ctrl) && $stable(pp_data)));
endmodule

bind pp_nibble_seq pp_nibble_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .pp_ctrl   (pp_ctrl),
    .pp_data   (pp_data)
);

// File: tb/pp_nibble_seq_test.sv
`timescale 1ns/1ps
module pp_nibble_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_hold = 8'd0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic       req_cmdset = 1'b0;
    logic [2:0] req_index = 3'd0;
    logic [7:0] req_wdata = 8'd0;
    logic [7:0] pp_status;
    logic [7:0] pp_data;
    logic [3:0] pp_ctrl;
    logic       busy;
    logic       done;
    logic [7:0] rdata;

    logic [7:0] dev_lo = 8'h00;
    logic [7:0] dev_hi = 8'h00;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state
    logic [7:0] m_data  = 8'h00;
    logic [3:0] m_ctrl  = 4'h4;
    logic [7:0] m_sdata = 8'h00;
    logic [3:0] m_sctrl = 4'h4;
    logic [7:0] m_rdata = 8'h00;

    always #2.5 clk = ~clk;

    assign pp_status = (pp_ctrl == 4'h6) ? dev_lo : dev_hi;

    pp_nibble_seq uut (
        .clk(clk), .rst(rst), .cfg_hold(cfg_hold), .req_valid(req_valid),
        .req_op(req_op), .req_cmdset(req_cmdset), .req_index(req_index),
        .req_wdata(req_wdata), .pp_status(pp_status), .pp_data(pp_data),
        .pp_ctrl(pp_ctrl), .busy(busy), .done(done), .rdata(rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int n_steps(input logic [1:0] op);
        case (op)
            2'd0: return 11;
            2'd1: return 13;
            2'd2: return 1;
            default: return 9;
        endcase
    endfunction

    function automatic logic [3:0] exp_ctrl(input logic [1:0] op, input int s);
        logic [3:0] dance [8] = '{4'h4, 4'hC, 4'hE, 4'hE, 4'hC, 4'h4, 4'h4, 4'h4};
        if (op == 2'd2) return 4'h4;
        if (s < 8) return dance[s];
        if (op == 2'd0) return (s == 8) ? 4'h6 : 4'h4;
        if (op == 2'd1) begin
            case (s)
                9:  return 4'h5;
                10: return 4'h7;
                11: return 4'h5;
                default: return 4'h4;
            endcase
        end
        return m_sctrl;
    endfunction

    task automatic run_op(input string tag, input logic [1:0] op, input bit cmdset,
                          input logic [2:0] idx, input logic [7:0] wd, input int dly,
                          input int poke_at, input int new_dly);
        logic [7:0] addr;
        logic [7:0] edata;
        int total;
        int s;
        addr  = (op == 2'd3) ? 8'h20 : (cmdset ? 8'h10 : 8'h08) + {5'd0, idx};
        total = n_steps(op) * (dly + 1);
        if (op == 2'd2) begin
            m_sdata = m_data;
            m_sctrl = m_ctrl;
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_cmdset = cmdset;
        req_index = idx; req_wdata = wd; cfg_hold = 8'(dly);
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_valid = 1'b0;
                cfg_hold  = 8'(new_dly);
            end
            if (poke_at > 0 && k == poke_at) begin
                req_valid = 1'b1; req_op = 2'd1; req_index = 3'd5; req_wdata = 8'hEE;
            end
            if (poke_at > 0 && k == poke_at + 1) req_valid = 1'b0;
            s = k / (dly + 1);
            case (op)
                2'd0: edata = addr;
                2'd1: edata = (s < 8) ? addr : wd;
                2'd2: edata = m_data;
                default: edata = (s < 8) ? addr : m_sdata;
            endcase
            check({tag, " R3/R4/R6/R7/R8/R9 ctrl"}, pp_ctrl, exp_ctrl(op, s));
            check({tag, " R2/R3/R6/R8 data"}, pp_data, edata);
            check({tag, " R10 busy"}, busy, 1);
        end
        @(negedge clk);
        check({tag, " R10 done"}, done, 1);
        check({tag, " R10 idle"}, busy, 0);
        if (op == 2'd0) m_rdata = {dev_hi[7:4], dev_lo[7:4]};
        check({tag, " R5 rdata"}, rdata, m_rdata);
        m_data = edata;
        m_ctrl = exp_ctrl(op, n_steps(op) - 1);
        @(negedge clk);
        check({tag, " R10 done width"}, done, 0);
        check({tag, " R11 no late start"}, busy, 0);
        check({tag, " R12 ctrl stable"}, pp_ctrl, m_ctrl);
        check({tag, " R12 data stable"}, pp_data, m_data);
    endtask

    task automatic t_reset();
        check("R1 ctrl", pp_ctrl, 4'h4);
        check("R1 data", pp_data, 8'h00);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 rdata", rdata, 8'h00);
    endtask

    task automatic t_idle_quiet();
        repeat (4) @(negedge clk);
        check("R12 idle ctrl", pp_ctrl, m_ctrl);
        check("R12 idle data", pp_data, m_data);
    endtask

    task automatic t_reads();
        dev_lo = 8'hA5; dev_hi = 8'h3C;
        run_op("read regs", 2'd0, 1'b0, 3'd3, 8'h00, 0, 0, 0);
        dev_lo = 8'h5F; dev_hi = 8'hC1;
        run_op("read cmds", 2'd0, 1'b1, 3'd7, 8'h00, 2, 0, 2);
    endtask

    task automatic t_writes();
        run_op("write regs", 2'd1, 1'b0, 3'd6, 8'hA0, 1, 0, 1);
        run_op("write cmds", 2'd1, 1'b1, 3'd0, 8'h55, 0, 0, 0);
    endtask

    task automatic t_hold_capture();
        dev_lo = 8'h96; dev_hi = 8'h69;
        run_op("R9 hold change", 2'd0, 1'b0, 3'd1, 8'h00, 3, 0, 0);
    endtask

    task automatic t_refuse();
        dev_lo = 8'h7E; dev_hi = 8'hB2;
        run_op("R11 refuse", 2'd0, 1'b1, 3'd2, 8'h00, 1, 4, 1);
    endtask

    task automatic t_session();
        run_op("R7 open", 2'd2, 1'b0, 3'd0, 8'h00, 1, 0, 1);
        dev_lo = 8'h12; dev_hi = 8'hF0;
        run_op("session read", 2'd0, 1'b0, 3'd4, 8'h00, 0, 0, 0);
        run_op("R8 close", 2'd3, 1'b0, 3'd0, 8'h00, 2, 0, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_quiet();
        t_reads();
        t_writes();
        t_hold_capture();
        t_refuse();
        t_session();
        t_idle_quiet();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule